// File: doc/BRIEF.md
# Single-CPU Interrupt Lifecycle Tracker with Acknowledge and Completion

The block tracks the lifecycle of a small set of interrupt IDs for one CPU. Each ID is always in exactly one of four states. Hardware request lines and a software-trigger strobe move IDs into the pending state. Each cycle, a combinational arbiter picks the best pending ID. That candidate is compared against a priority mask and against the priority of the work the CPU is already servicing. If it qualifies, a single interrupt line to the CPU goes high.

The CPU reads an acknowledge port to learn which ID to service. The read activates that ID, or returns the reserved spurious value 1023 when nothing qualifies. The CPU later writes the ID to a completion port to finish the handler.

The register-style ports are plain single-cycle strobes with no back-pressure. Every strobe is accepted in the cycle it is high, and the block never stalls.

Top module: `irq_ack_core`

## Requirements
- R1: After reset every ID is inactive, `irq_o` is low and `ack_id` reads 1023.
- R2: A request on an inactive ID makes it pending. IDs 16 and up are requested through `irq_in[id-16]`, which is high for one cycle per request.
- R3: A request on an ID that is already pending has no effect, so any number of requests collapse into one acknowledge.
- R4: A request on an active ID makes it active-and-pending. After its completion the ID is pending again and signals anew.
- R5: Among pending IDs the lowest numeric priority value wins, and a tie goes to the lowest ID. Priorities are 4-bit fields in `prio_cfg`, with the field for ID n at bits [4n+3:4n].
- R6: `irq_o` rises only when the winner's priority value is strictly below `prio_mask`.
- R7: `irq_o` rises only when the winner's priority value is strictly below the lowest priority value among active and active-and-pending IDs.
- R8: An `ack_rd` strobe while `irq_o` is high loads the winner's ID into `ack_id`, visible after that clock edge, and makes the winner active.
- R9: An `ack_rd` strobe while `irq_o` is low loads 1023 into `ack_id` and changes no state.
- R10: An `eoi_wr` strobe naming an active ID makes it inactive, and one naming an active-and-pending ID makes it pending. A strobe naming any other ID, including IDs outside the implemented range, is ignored.
- R11: An `sgi_wr` strobe with `sgi_id` in 0..15 requests that software ID. A strobe with any larger value is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_IRQ-16 | One-cycle request pulses for IDs 16 and up |
| prio_cfg | input | NUM_IRQ*PRIO_W | Per-ID priority values |
| prio_mask | input | PRIO_W | Priority mask threshold |
| sgi_wr | input | 1 | Software request strobe |
| sgi_id | input | 10 | ID to request in software |
| ack_rd | input | 1 | Acknowledge read strobe |
| ack_id | output | 10 | ID returned by the last acknowledge |
| eoi_wr | input | 1 | Completion write strobe |
| eoi_id | input | 10 | ID being completed |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
The bench loads 32 IDs with scattered priorities, requests them all at once and drains them by acknowledge and completion, checking the exact service order. A design that breaks ties by the highest ID, or that compares the mask non-strictly, would return the wrong sequence.

Directed cases then cover the following:
- Repeated requests that must collapse into one acknowledge; a queuing design would return the same ID twice.
- A request landing during service that must come back after completion; a design that drops it would answer 1023.
- Equal-priority work that must stay blocked while another ID is active.
- Completions and software writes naming the wrong ID, which a careless decoder would act on.
- An acknowledge with nothing qualifying, which must leave pending work untouched.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PEND    = 2'd1,
    ST_ACT     = 2'd2,
    ST_ACTPEND = 2'd3
  } irq_st_e;

  localparam int ID_W = 10;
  localparam int SGI_COUNT = 16;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;
endpackage

// File: rtl/irqc_cell.sv
module irqc_cell
  import irqc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic raise,
  input  logic take,
  input  logic finish,
  output logic pend_o,
  output logic act_o
);
  irq_st_e st, s_take, s_fin, s_next;

  always_comb begin
    s_take = (take && st == ST_PEND) ? ST_ACT : st;
    s_fin = s_take;
    if (finish) begin
      if (s_take == ST_ACT) s_fin = ST_IDLE;
      else if (s_take == ST_ACTPEND) s_fin = ST_PEND;
    end
    s_next = s_fin;
    if (raise) begin
      if (s_fin == ST_IDLE) s_next = ST_PEND;
      else if (s_fin == ST_ACT) s_next = ST_ACTPEND;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else st <= s_next;
  end

  assign pend_o = (st == ST_PEND);
  assign act_o  = (st == ST_ACT) || (st == ST_ACTPEND);

  // R2
  idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_IDLE |=> (st == ST_IDLE || st == ST_PEND));
  // R3
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PEND && !take) |=> st == ST_PEND);
  // R10
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACT && !finish) |=> (st == ST_ACT || st == ST_ACTPEND));
endmodule

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick #(
  parameter int N  = 32,
  parameter int PW = 4,
  parameter int IW = 10
) (
  input  logic [N-1:0]    req,
  input  logic [N*PW-1:0] prio_flat,
  output logic            found,
  output logic [IW-1:0]   win_id,
  output logic [PW-1:0]   win_prio
);
  always_comb begin
    found    = 1'b0;
    win_id   = '0;
    win_prio = '1;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!found || prio_flat[i*PW +: PW] < win_prio)) begin
        found    = 1'b1;
        win_id   = IW'(i);
        win_prio = prio_flat[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/irq_ack_core.sv
module irq_ack_core
  import irqc_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IRQ-SGI_COUNT-1:0] irq_in,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_cfg,
  input  logic [PRIO_W-1:0]         prio_mask,
  input  logic                      sgi_wr,
  input  logic [ID_W-1:0]           sgi_id,
  input  logic                      ack_rd,
  output logic [ID_W-1:0]           ack_id,
  input  logic                      eoi_wr,
  input  logic [ID_W-1:0]           eoi_id,
  output logic                      irq_o
);
  localparam int RUN_W = PRIO_W + 1;
  localparam logic [RUN_W-1:0] RUN_IDLE = RUN_W'(1) << PRIO_W;

  logic [NUM_IRQ-1:0] pend, act, raise_v, take_v, finish_v;
  logic               pend_found, act_found, fire;
  logic [ID_W-1:0]    pend_win, act_win;
  logic [PRIO_W-1:0]  pend_prio, act_prio;
  logic [RUN_W-1:0]   run_prio;

  irqc_prio_pick #(.N(NUM_IRQ), .PW(PRIO_W), .IW(ID_W)) pend_pick_i (
    .req(pend), .prio_flat(prio_cfg), .found(pend_found),
    .win_id(pend_win), .win_prio(pend_prio));

  irqc_prio_pick #(.N(NUM_IRQ), .PW(PRIO_W), .IW(ID_W)) act_pick_i (
    .req(act), .prio_flat(prio_cfg), .found(act_found),
    .win_id(act_win), .win_prio(act_prio));

  assign run_prio = act_found ? {1'b0, act_prio} : RUN_IDLE;
  assign fire = pend_found && ({1'b0, pend_prio} < run_prio) && (pend_prio < prio_mask);
  assign irq_o = fire;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_id
    if (g < SGI_COUNT) begin : g_sw
      assign raise_v[g] = sgi_wr && (sgi_id == ID_W'(g));
    end else begin : g_hw
      assign raise_v[g] = irq_in[g-SGI_COUNT];
    end
    assign take_v[g]   = ack_rd && fire && (pend_win == ID_W'(g));
    assign finish_v[g] = eoi_wr && (eoi_id == ID_W'(g));

    irqc_cell cell_i (
      .clk(clk), .rst_n(rst_n), .raise(raise_v[g]), .take(take_v[g]),
      .finish(finish_v[g]), .pend_o(pend[g]), .act_o(act[g]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ack_id <= SPURIOUS_ID;
    else if (ack_rd) ack_id <= fire ? pend_win : SPURIOUS_ID;
  end

  // R8
  one_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_v));
  // R8
  ack_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && irq_o) |=> ack_id != SPURIOUS_ID);
  // R9
  ack_spur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !irq_o) |=> ack_id == SPURIOUS_ID);
  // R10
  run_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_found && !(eoi_wr && eoi_id == act_win)) |=> act_found);
endmodule

// File: tb/irq_ack_core_tb_top.sv
`timescale 1ns/1ps
module irq_ack_core_tb_top;
  localparam int N = 32;
  localparam int PW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-17:0] irq_in = '0;
  logic [N*PW-1:0] prio_cfg = '0;
  logic [PW-1:0] prio_mask = '1;
  logic sgi_wr = 1'b0, ack_rd = 1'b0, eoi_wr = 1'b0;
  logic [9:0] sgi_id = '0, eoi_id = '0;
  logic [9:0] ack_id;
  logic irq_o;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_ack_core #(.NUM_IRQ(N), .PRIO_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .prio_cfg(prio_cfg),
    .prio_mask(prio_mask), .sgi_wr(sgi_wr), .sgi_id(sgi_id),
    .ack_rd(ack_rd), .ack_id(ack_id), .eoi_wr(eoi_wr), .eoi_id(eoi_id),
    .irq_o(irq_o));

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic hw_req(int id);
    irq_in[id-16] = 1'b1;
    @(negedge clk);
    irq_in = '0;
  endtask

  task automatic sw_req(int id);
    sgi_wr = 1'b1; sgi_id = 10'(id);
    @(negedge clk);
    sgi_wr = 1'b0;
  endtask

  task automatic do_ack(output int id);
    ack_rd = 1'b1;
    @(negedge clk);
    ack_rd = 1'b0;
    id = int'(ack_id);
  endtask

  task automatic do_eoi(int id);
    eoi_wr = 1'b1; eoi_id = 10'(id);
    @(negedge clk);
    eoi_wr = 1'b0;
  endtask

  task automatic all_prio(int p);
    for (int i = 0; i < N; i++) prio_cfg[i*PW +: PW] = PW'(p);
  endtask

  initial begin
    int got;
    int exp_id;
    int best;
    logic [N-1:0] rem;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 irq_o", int'(irq_o), 0);
    check("R1 ack_id", int'(ack_id), 1023);
    do_reset();

    // Sweep: all IDs pending, scattered priorities, drain in order (R5 R6 R7 R8)
    for (int i = 0; i < N; i++) prio_cfg[i*PW +: PW] = PW'((i * 5 + 3) % 16);
    prio_mask = 4'd15;
    for (int i = 0; i < 16; i++) sw_req(i);
    irq_in = '1;
    @(negedge clk);
    irq_in = '0;
    rem = '1;
    for (int k = 0; k < 30; k++) begin
      best = 99; exp_id = 1023;
      for (int i = 0; i < N; i++)
        if (rem[i] && ((i * 5 + 3) % 16) < 15 && ((i * 5 + 3) % 16) < best) begin
          best = (i * 5 + 3) % 16; exp_id = i;
        end
      check("R6 irq_o before ack", int'(irq_o), 1);
      do_ack(got);
      check("R5 sweep order", got, exp_id);
      check("R7 blocked while serving", int'(irq_o), 0);
      do_eoi(exp_id);
      rem[exp_id] = 1'b0;
    end
    // R6 prio 15 never passes mask 15
    check("R6 masked irq_o", int'(irq_o), 0);
    do_ack(got);
    check("R9 nothing qualifies", got, 1023);

    // Mask strictness and spurious ack without state change (R6 R9)
    do_reset();
    all_prio(5);
    prio_mask = 4'd5;
    hw_req(20);
    check("R6 equal to mask blocked", int'(irq_o), 0);
    do_ack(got);
    check("R9 spurious", got, 1023);
    prio_mask = 4'd6;
    #1;
    check("R2 pending signalled", int'(irq_o), 1);
    do_ack(got);
    check("R8 ack id", got, 20);
    do_eoi(20);

    // Collapse (R3)
    do_reset();
    all_prio(5);
    prio_mask = 4'd15;
    hw_req(20); hw_req(20); hw_req(20);
    do_ack(got);
    check("R3 first ack", got, 20);
    do_eoi(20);
    check("R3 no second request", int'(irq_o), 0);
    do_ack(got);
    check("R3 no repeat", got, 1023);

    // Active-and-pending (R4)
    hw_req(22);
    do_ack(got);
    check("R8 ack 22", got, 22);
    hw_req(22);
    check("R4 blocked while active", int'(irq_o), 0);
    do_eoi(22);
    check("R4 signals again", int'(irq_o), 1);
    do_ack(got);
    check("R4 re-ack", got, 22);
    do_eoi(22);

    // Running priority and ignored completions (R7 R10)
    hw_req(20);
    do_ack(got);
    hw_req(21);
    check("R7 equal prio blocked", int'(irq_o), 0);
    do_eoi(30);
    check("R10 eoi on inactive ignored", int'(irq_o), 0);
    do_eoi(1023);
    check("R10 eoi out of range ignored", int'(irq_o), 0);
    prio_cfg[25*PW +: PW] = 4'd2;
    hw_req(25);
    check("R7 preempt higher prio", int'(irq_o), 1);
    do_ack(got);
    check("R7 preempt id", got, 25);
    do_eoi(25);
    check("R10 back to 20 running", int'(irq_o), 0);
    do_eoi(20);
    check("R10 eoi releases", int'(irq_o), 1);
    do_ack(got);
    check("R10 next id", got, 21);
    do_eoi(21);

    // Ties (R5)
    hw_req(25);
    prio_cfg[25*PW +: PW] = 4'd5;
    hw_req(17);
    do_ack(got);
    check("R5 tie lowest id", got, 17);
    do_eoi(17);
    do_ack(got);
    check("R5 tie second", got, 25);
    do_eoi(25);

    // Software requests (R11)
    sw_req(3);
    check("R11 sgi pending", int'(irq_o), 1);
    do_ack(got);
    check("R11 sgi id", got, 3);
    do_eoi(3);
    sw_req(40);
    sw_req(20);
    check("R11 sgi id>15 ignored", int'(irq_o), 0);
    do_ack(got);
    check("R11 ignored ack", got, 1023);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule